// File: doc/BRIEF.md
# Bidirectional Open-Drain Line Repeater

This block joins two open-drain signal lines, a card-side line and a controller-side line, and copies a low level from whichever side pulls low first onto the other. Both line levels arrive as sampled digital inputs. For each side the block drives a pull-low enable and a strong pull-up boost enable. The analog pads, the resistors and the level shifting sit outside the block. Only arbitration and timing are modelled here.

In the idle state both lines are high and the block watches both sides for a falling edge. The side seen falling first becomes the master. Edge detection on the other side, the slave, is ignored from that moment, so the low the block drives onto the slave cannot claim mastership. After `TD_CYCLES` clock cycles the slave is pulled low. When the master line goes high again, the slave pull-low is released and the slave boost is enabled for `TD_CYCLES` cycles. The block then returns to idle. If the slave line is still low when the boost ends, the block enters a conflict state with every drive released, and it leaves that state only when both lines are seen high.

The chip-select input chooses the controller-side pull-up mode. While it is low, the controller line is held high by the weak resistor and no transfer can take place. The states are `ST_IDLE`, `ST_CARD_WAIT`, `ST_CARD_DRIVE`, `ST_CTRL_WAIT`, `ST_CTRL_DRIVE`, `ST_BOOST_CTRL`, `ST_BOOST_CARD` and `ST_CONFLICT`. Their transitions are:

- IDLE to CARD_WAIT or CTRL_WAIT on a falling edge.
- WAIT to DRIVE when the delay ends.
- WAIT to IDLE when the master returns high early.
- DRIVE to BOOST when the master returns high.
- BOOST to IDLE, or to CONFLICT if the slave line is still low.
- CONFLICT to IDLE when both lines are high.
- Any state to IDLE when chip select is low.

`TD_CYCLES` must be at least 3. For 200 kHz line toggling, twice `TD_CYCLES` clock periods must fit within 2.5 µs.

Top module: `odl_repeater`

## Requirements
- R1: After reset, `status_o` is 0 (idle) and all four pull-low and boost outputs are 0. The status codes are:
  - 0: idle
  - 1: card master
  - 2: controller master
  - 3: boost
  - 4: conflict
- R2: `ctrl_weak_pu_o` equals `cs_i`. A value of 1 selects the 20 kΩ pull-up and 0 selects the permanent-high 100 kΩ mode.
- R3: A line input falling while idle makes that side the master. `status_o` becomes 1 for the card side or 2 for the controller side on the third rising clock edge after the line falls (two synchronizer flops plus the state register).
- R4: If both lines fall in the same cycle, the controller side becomes master (`status_o` = 2).
- R5: The slave pull-low asserts `TD_CYCLES` cycles after the master status appears. It does so only if the master stayed low throughout that wait.
  - A master low lasting L cycles yields max(0, L − `TD_CYCLES`) cycles of slave pull-low.
  - The master-side pull-low never asserts.
- R6: The low the block drives onto the slave never makes the slave a master. After a transfer the block returns to idle without starting a reverse transfer.
- R7: When the master line rises after a transfer, the slave pull-low drops and the slave boost is enabled for exactly `TD_CYCLES` cycles (`status_o` = 3).
  - The boost starts on the third rising edge after the master line rises.
  - A master pulse too short to transfer gives no boost.
- R8: If the slave line is still low when the boost ends, `status_o` becomes 4 with every drive released. It stays 4 while either line is low. It returns to 0 on the third edge after both lines are high.
- R9: While `cs_i` is low, the block is idle (status 0, all drives 0) from the next clock edge on, and falling edges on either line are ignored. A line already low when `cs_i` rises does not start a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, synchronous to `clk_i` |
| card_line_i | input | 1 | Sampled card-side line level |
| ctrl_line_i | input | 1 | Sampled controller-side line level |
| card_pull_low_o | output | 1 | Card-side pull-low enable |
| ctrl_pull_low_o | output | 1 | Controller-side pull-low enable |
| card_boost_o | output | 1 | Card-side strong pull-up enable |
| ctrl_boost_o | output | 1 | Controller-side strong pull-up enable |
| ctrl_weak_pu_o | output | 1 | Controller-side pull-up mode: 1 = 20 kΩ, 0 = permanent high via 100 kΩ |
| status_o | output | 3 | Current state code, as listed in R1 |

## Verification
The assertions assume the following about the inputs:
- `cs_i` is synchronous to the clock, since it is not resynchronized. The cs-related properties look one edge back at it.
- `TD_CYCLES` is at least 3, so that a released slave line is seen high again before its boost ends.

The stimulus changes inputs only on falling clock edges. It models each line as a wired-AND of an external low and the block's own pull-low, so the slave really goes low when driven, and the controller line reads high while chip select is low. The bench sweeps the master pulse length from 1 to 3·`TD_CYCLES` cycles in both directions and computes the expected pull-low and boost lengths from the pulse length.

// File: rtl/odl_pkg.sv
package odl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CARD_WAIT,
        ST_CARD_DRIVE,
        ST_CTRL_WAIT,
        ST_CTRL_DRIVE,
        ST_BOOST_CTRL,
        ST_BOOST_CARD,
        ST_CONFLICT
    } odl_state_e;

    localparam int unsigned STAT_W = 3;

    localparam logic [STAT_W-1:0] STAT_IDLE     = 3'd0;
    localparam logic [STAT_W-1:0] STAT_CARD_MST = 3'd1;
    localparam logic [STAT_W-1:0] STAT_CTRL_MST = 3'd2;
    localparam logic [STAT_W-1:0] STAT_BOOST    = 3'd3;
    localparam logic [STAT_W-1:0] STAT_CONFLICT = 3'd4;

    localparam int unsigned SIDE_CARD = 0;
    localparam int unsigned SIDE_CTRL = 1;
    localparam int unsigned N_SIDES   = 2;

endpackage

// File: rtl/odl_sync.sv
module odl_sync #(
    parameter int unsigned WIDTH   = 2,
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int s = 0; s < STAGES; s++) begin
                pipe[s] <= {WIDTH{RST_VAL}};
            end
        end else begin
            pipe[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/odl_fall_det.sv
module odl_fall_det #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] fall_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic prev_q;

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                prev_q <= 1'b1;
            end else begin
                prev_q <= level_i[b];
            end
        end

        assign fall_o[b] = prev_q & ~level_i[b];
    end

endmodule

// File: rtl/odl_timer.sv
module odl_timer #(
    parameter int unsigned TD_CYCLES = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    output logic done_o
);

    localparam int unsigned CNT_W = (TD_CYCLES < 2) ? 1 : $clog2(TD_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TD_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = (cnt_q == LAST);

endmodule

// File: rtl/odl_repeater.sv
module odl_repeater
    import odl_pkg::*;
#(
    parameter int unsigned TD_CYCLES   = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cs_i,
    input  logic              card_line_i,
    input  logic              ctrl_line_i,
    output logic              card_pull_low_o,
    output logic              ctrl_pull_low_o,
    output logic              card_boost_o,
    output logic              ctrl_boost_o,
    output logic              ctrl_weak_pu_o,
    output logic [STAT_W-1:0] status_o
);

    logic [N_SIDES-1:0] line_raw;
    logic [N_SIDES-1:0] line_s;
    logic [N_SIDES-1:0] fall;
    logic               card_s;
    logic               ctrl_s;
    logic               card_fall;
    logic               ctrl_fall;
    logic               td_done;
    logic               state_change;

    odl_state_e state_q;
    odl_state_e state_d;

    assign line_raw[SIDE_CARD] = card_line_i;
    assign line_raw[SIDE_CTRL] = ctrl_line_i;

    odl_sync #(
        .WIDTH   (N_SIDES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (line_raw),
        .q_o    (line_s)
    );

    odl_fall_det #(
        .WIDTH (N_SIDES)
    ) u_fall (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .level_i (line_s),
        .fall_o  (fall)
    );

    assign card_s    = line_s[SIDE_CARD];
    assign ctrl_s    = line_s[SIDE_CTRL];
    assign card_fall = fall[SIDE_CARD];
    assign ctrl_fall = fall[SIDE_CTRL];

    assign state_change = (state_d != state_q);

    odl_timer #(
        .TD_CYCLES (TD_CYCLES)
    ) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (state_change),
        .done_o  (td_done)
    );

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: the slave side's level and edges are not looked at
    // while a master holds the bus.
    always_comb begin
        state_d = state_q;
        if (!cs_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (ctrl_fall) begin
                        state_d = ST_CTRL_WAIT;
                    end else if (card_fall) begin
                        state_d = ST_CARD_WAIT;
                    end
                end
                ST_CARD_WAIT: begin
                    if (card_s) begin
                        state_d = ST_IDLE;
                    end else if (td_done) begin
                        state_d = ST_CARD_DRIVE;
                    end
                end
                ST_CARD_DRIVE: begin
                    if (card_s) begin
                        state_d = ST_BOOST_CTRL;
                    end
                end
                ST_CTRL_WAIT: begin
                    if (ctrl_s) begin
                        state_d = ST_IDLE;
                    end else if (td_done) begin
                        state_d = ST_CTRL_DRIVE;
                    end
                end
                ST_CTRL_DRIVE: begin
                    if (ctrl_s) begin
                        state_d = ST_BOOST_CARD;
                    end
                end
                ST_BOOST_CTRL: begin
                    if (td_done) begin
                        state_d = ctrl_s ? ST_IDLE : ST_CONFLICT;
                    end
                end
                ST_BOOST_CARD: begin
                    if (td_done) begin
                        state_d = card_s ? ST_IDLE : ST_CONFLICT;
                    end
                end
                ST_CONFLICT: begin
                    if (card_s && ctrl_s) begin
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Output decode
    always_comb begin
        card_pull_low_o = 1'b0;
        ctrl_pull_low_o = 1'b0;
        card_boost_o    = 1'b0;
        ctrl_boost_o    = 1'b0;
        status_o        = STAT_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                status_o = STAT_IDLE;
            end
            ST_CARD_WAIT: begin
                status_o = STAT_CARD_MST;
            end
            ST_CARD_DRIVE: begin
                status_o        = STAT_CARD_MST;
                ctrl_pull_low_o = 1'b1;
            end
            ST_CTRL_WAIT: begin
                status_o = STAT_CTRL_MST;
            end
            ST_CTRL_DRIVE: begin
                status_o        = STAT_CTRL_MST;
                card_pull_low_o = 1'b1;
            end
            ST_BOOST_CTRL: begin
                status_o     = STAT_BOOST;
                ctrl_boost_o = 1'b1;
            end
            ST_BOOST_CARD: begin
                status_o     = STAT_BOOST;
                card_boost_o = 1'b1;
            end
            ST_CONFLICT: begin
                status_o = STAT_CONFLICT;
            end
            default: status_o = STAT_IDLE;
        endcase
    end

    assign ctrl_weak_pu_o = cs_i;

endmodule

// File: rtl/odl_repeater_chk.sv
module odl_repeater_chk
    import odl_pkg::*;
#(
    parameter int unsigned TD_CYCLES = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cs_i,
    input logic              card_pull_low_o,
    input logic              ctrl_pull_low_o,
    input logic              card_boost_o,
    input logic              ctrl_boost_o,
    input logic [STAT_W-1:0] status_o
);

    localparam int unsigned RUN_W = $clog2(TD_CYCLES + 2);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(TD_CYCLES + 1);

    logic             any_boost;
    logic [RUN_W-1:0] boost_run;

    assign any_boost = card_boost_o | ctrl_boost_o;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            boost_run <= '0;
        end else if (any_boost) begin
            if (boost_run != RUN_MAX) begin
                boost_run <= boost_run + 1'b1;
            end
        end else begin
            boost_run <= '0;
        end
    end

    assert_status_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        status_o <= STAT_CONFLICT);

    assert_one_slave_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(card_pull_low_o && ctrl_pull_low_o));

    assert_ctrl_pull_from_card_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ctrl_pull_low_o) |-> $past(status_o) == STAT_CARD_MST);

    assert_card_pull_from_ctrl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(card_pull_low_o) |-> $past(status_o) == STAT_CTRL_MST);

    assert_no_fight_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(card_pull_low_o && card_boost_o) && !(ctrl_pull_low_o && ctrl_boost_o));

    assert_release_boost_ctrl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(ctrl_pull_low_o) && $past(cs_i)) |-> ctrl_boost_o);

    assert_release_boost_card_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(card_pull_low_o) && $past(cs_i)) |-> card_boost_o);

    assert_boost_max_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        boost_run <= RUN_W'(TD_CYCLES));

    assert_boost_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(any_boost) && $past(cs_i)) |-> boost_run == RUN_W'(TD_CYCLES));

    assert_conflict_exit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        status_o == STAT_CONFLICT |=> (status_o == STAT_CONFLICT || status_o == STAT_IDLE));

    assert_cs_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cs_i |=> (!card_pull_low_o && !ctrl_pull_low_o && !card_boost_o
                   && !ctrl_boost_o && status_o == STAT_IDLE));

endmodule

bind odl_repeater odl_repeater_chk #(
    .TD_CYCLES (TD_CYCLES)
) u_chk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .cs_i            (cs_i),
    .card_pull_low_o (card_pull_low_o),
    .ctrl_pull_low_o (ctrl_pull_low_o),
    .card_boost_o    (card_boost_o),
    .ctrl_boost_o    (ctrl_boost_o),
    .status_o        (status_o)
);

// File: tb/tb_odl_repeater.sv
`timescale 1ns/1ps
module tb_odl_repeater;

    localparam int TD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b1;
    logic       ext_card = 1'b0;
    logic       ext_ctrl = 1'b0;
    logic       card_line;
    logic       ctrl_line;
    logic       card_pull_low;
    logic       ctrl_pull_low;
    logic       card_boost;
    logic       ctrl_boost;
    logic       ctrl_weak_pu;
    logic [2:0] status;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    // Wired-AND line model; controller line reads high while cs is low
    assign card_line = ~(ext_card | card_pull_low);
    assign ctrl_line = cs ? ~(ext_ctrl | ctrl_pull_low) : 1'b1;

    odl_repeater #(
        .TD_CYCLES   (TD),
        .SYNC_STAGES (2)
    ) dut (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .cs_i            (cs),
        .card_line_i     (card_line),
        .ctrl_line_i     (ctrl_line),
        .card_pull_low_o (card_pull_low),
        .ctrl_pull_low_o (ctrl_pull_low),
        .card_boost_o    (card_boost),
        .ctrl_boost_o    (ctrl_boost),
        .ctrl_weak_pu_o  (ctrl_weak_pu),
        .status_o        (status)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // One master pulse of length L; side 0 = card master, 1 = controller master
    task automatic pulse(input int side, input int L);
        int slave_pull = 0;
        int master_pull = 0;
        int slave_boost = 0;
        int first_boost = -1;
        int stat3 = -1;
        int exp_pull;
        int exp_boost;
        int exp_stat;
        if (side == 0) ext_card = 1'b1; else ext_ctrl = 1'b1;
        for (int i = 1; i <= L + TD + 12; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i == 3) stat3 = int'(status);
            if (side == 0) begin
                slave_pull  += int'(ctrl_pull_low);
                master_pull += int'(card_pull_low);
                if (ctrl_boost && first_boost < 0) first_boost = i;
                slave_boost += int'(ctrl_boost);
            end else begin
                slave_pull  += int'(card_pull_low);
                master_pull += int'(ctrl_pull_low);
                if (card_boost && first_boost < 0) first_boost = i;
                slave_boost += int'(card_boost);
            end
            if (i == L) begin
                ext_card = 1'b0;
                ext_ctrl = 1'b0;
            end
        end
        exp_pull  = (L > TD) ? L - TD : 0;
        exp_boost = (L > TD) ? TD : 0;
        exp_stat  = (side == 0) ? 1 : 2;
        chk(stat3 == exp_stat, "R3 master status on third edge", stat3, exp_stat);
        chk(slave_pull == exp_pull, "R5 slave pull-low cycles", slave_pull, exp_pull);
        chk(master_pull == 0, "R5 master side never pulled", master_pull, 0);
        chk(slave_boost == exp_boost, "R7 slave boost cycles", slave_boost, exp_boost);
        if (L > TD) begin
            chk(first_boost == L + 3, "R7 boost start edge", first_boost, L + 3);
        end
        chk(status == 3'd0, "R6 back to idle, no reverse transfer", int'(status), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int bad;
        tick(5);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state
        chk(status == 3'd0, "R1 status idle", int'(status), 0);
        chk({card_pull_low, ctrl_pull_low, card_boost, ctrl_boost} == 4'b0,
            "R1 drives off", int'({card_pull_low, ctrl_pull_low, card_boost, ctrl_boost}), 0);
        // R2 pull-up mode follows cs
        chk(ctrl_weak_pu == 1'b1, "R2 weak pull-up with cs high", int'(ctrl_weak_pu), 1);
        cs = 1'b0;
        tick(1);
        chk(ctrl_weak_pu == 1'b0, "R2 pull-up mode with cs low", int'(ctrl_weak_pu), 0);
        cs = 1'b1;
        tick(3);

        // R3 R5 R6 R7 sweep of pulse length in both directions
        for (int side = 0; side < 2; side++) begin
            for (int L = 1; L <= 3 * TD; L++) begin
                pulse(side, L);
            end
        end

        // R4 simultaneous fall, then R8 conflict
        ext_card = 1'b1;
        ext_ctrl = 1'b1;
        for (int i = 1; i <= 26; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i == 3) chk(status == 3'd2, "R4 controller wins tie", int'(status), 2);
            if (i == 8) chk(card_pull_low == 1'b1, "R4 card driven as slave", int'(card_pull_low), 1);
            if (i == 14) chk(card_boost == 1'b1, "R7 card boost after release", int'(card_boost), 1);
            if (i == 13 + TD) chk(status == 3'd4, "R8 conflict entered", int'(status), 4);
            if (i == 21) begin
                chk(status == 3'd4, "R8 conflict held", int'(status), 4);
                chk({card_pull_low, ctrl_pull_low, card_boost, ctrl_boost} == 4'b0,
                    "R8 drives released in conflict",
                    int'({card_pull_low, ctrl_pull_low, card_boost, ctrl_boost}), 0);
            end
            if (i == 24) chk(status == 3'd4, "R8 conflict until both high", int'(status), 4);
            if (i == 25) chk(status == 3'd0, "R8 idle after both high", int'(status), 0);
            if (i == 10) ext_ctrl = 1'b0;
            if (i == 22) ext_card = 1'b0;
        end
        tick(4);

        // R9 edges ignored while cs is low
        cs = 1'b0;
        tick(1);
        ext_card = 1'b1;
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            tick(1);
            if (status != 3'd0 || ctrl_pull_low || card_pull_low) bad++;
        end
        chk(bad == 0, "R9 no transfer with cs low", bad, 0);
        ext_card = 1'b0;
        tick(4);
        cs = 1'b1;
        tick(4);

        // R9 cs drop mid-transfer, then no restart on a line already low
        ext_card = 1'b1;
        tick(3 + TD + 1);
        chk(ctrl_pull_low == 1'b1, "R5 transfer under way", int'(ctrl_pull_low), 1);
        cs = 1'b0;
        tick(1);
        chk(status == 3'd0, "R9 cs low forces idle", int'(status), 0);
        chk(ctrl_pull_low == 1'b0, "R9 cs low releases drive", int'(ctrl_pull_low), 0);
        cs = 1'b1;
        tick(6);
        chk(status == 3'd0, "R9 held-low line does not restart", int'(status), 0);
        ext_card = 1'b0;
        tick(6);
        chk(status == 3'd0, "R9 idle after release", int'(status), 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule